// File: doc/BRIEF.md
# Fast-Infrared Receive Byte Escaper

This block sits on the fast-infrared receive path, between the pulse-position demodulator and the receive FIFO. The demodulator hands it decoded bytes plus strobes that mark where a frame opens and closes. The block writes the frame to the FIFO as a byte stream with valid/ready.

Each frame opens and closes with a pair of 0x7E delimiter bytes. Inside a frame, any byte that could be mistaken for a delimiter or an escape is rewritten as a two-byte escape sequence. After that, 0x7E appears in the FIFO only as a frame boundary. The block does not check the CRC or validate the frame: every byte, the four CRC bytes included, is forwarded. Host software removes the escapes.

The demodulator works in real time and does not wait. For that reason the input side is made of strobes, and the input ready signal is only a hint. A strobe that arrives while the block cannot take it is lost. A lost strobe sets a sticky overflow flag, which stays set until a status read clears it.

Top module: `frx_escaper`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1 and `ovf_flag` is 0.
- R2: A frame-open strobe (`in_sof`) produces exactly two output bytes, both 0x7E.
- R3: A frame-close strobe (`in_eof`) produces two 0x7E bytes. They follow every byte accepted before the close.
- R4: A data byte of 0x7D, 0x7E or 0x7F is output as 0x7D followed by the byte XOR 0x20 (0x5D, 0x5E, 0x5F). A bare 0x7F never appears on the output.
- R5: Every other data byte, the CRC bytes included, is output unchanged and in arrival order. No byte is removed or checked.
- R6: Any input that produces two output bytes drives `in_ready` low in the next cycle. `in_ready` stays low until the second byte has been taken.
- R7: A close strobe that arrives while an escape pair or a delimiter pair is still being output is held, not lost. Its two 0x7E bytes follow the pair, and `ovf_flag` stays 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R9: A data or open strobe that arrives while `in_ready` is 0 is dropped, and `ovf_flag` is 1 from the next cycle on. The same applies to a close strobe that arrives while an earlier close is still held.
- R10: `stat_rd` clears `ovf_flag` in the next cycle. If a drop happens in the same cycle, the flag stays set.
- R11: A byte accepted at a clock edge is on `out_data`, with `out_valid` high, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data byte strobe from the demodulator |
| in_data | input | 8 | Decoded data byte |
| in_sof | input | 1 | Frame-open strobe |
| in_eof | input | 1 | Frame-close strobe |
| in_ready | output | 1 | A data or open strobe in this cycle will be taken |
| out_valid | output | 1 | Output byte valid toward the FIFO |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | FIFO can take a byte |
| stat_rd | input | 1 | Status read; clears the overflow flag |
| ovf_flag | output | 1 | Sticky lost-input flag |

## Verification
A strobe that is accepted at a rising edge places its first byte on the output right after that edge, and a second byte follows one cycle after the first is taken. `in_ready` and `ovf_flag` respond one edge after the strobe that affects them. The bench changes inputs on falling edges and reads the outputs at the next falling edge, so each one-cycle result is read half a period after the edge that produced it. Byte streams are collected at rising edges where `out_valid` and `out_ready` are both high. Each stream is compared against a sequence that the bench builds from the escape rule, once the pipeline has had several idle cycles to drain.

// File: rtl/frx_esc_pkg.sv
package frx_esc_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CH_DELIM = 8'h7E;
    localparam byte_t CH_ESC   = 8'h7D;
    localparam byte_t CH_TOP   = 8'h7F;
    localparam byte_t ESC_FLIP = 8'h20;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_DATA  = 2'd1,
        EV_OPEN  = 2'd2,
        EV_CLOSE = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic  two;
        byte_t first;
        byte_t second;
    } emit_t;

    function automatic logic needs_escape(byte_t b);
        return (b == CH_ESC) || (b == CH_DELIM) || (b == CH_TOP);
    endfunction

    function automatic emit_t encode_event(ev_kind_e k, byte_t b);
        emit_t e;
        e = '0;
        case (k)
            EV_DATA: begin
                if (needs_escape(b)) begin
                    e.two    = 1'b1;
                    e.first  = CH_ESC;
                    e.second = b ^ ESC_FLIP;
                end else begin
                    e.first = b;
                end
            end
            EV_OPEN, EV_CLOSE: begin
                e.two    = 1'b1;
                e.first  = CH_DELIM;
                e.second = CH_DELIM;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/frx_esc_encode.sv
module frx_esc_encode
    import frx_esc_pkg::*;
(
    input  ev_kind_e kind,
    input  byte_t    data,
    output emit_t    emit
);

    always_comb begin
        emit = encode_event(kind, data);
    end

endmodule

// File: rtl/frx_esc_seq.sv
module frx_esc_seq
    import frx_esc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ev_kind_e kind,
    input  emit_t    emit,
    input  logic     out_ready,
    output logic     out_valid,
    output byte_t    out_data,
    output logic     in_ready,
    output logic     drop
);

    logic  head_v;
    byte_t head_d;
    logic  sec_v;
    byte_t sec_d;
    logic  close_pend;

    logic free;
    logic take;
    logic park;

    always_comb begin
        free     = !head_v || out_ready;
        in_ready = free && !sec_v && !close_pend;
        take     = in_ready && (kind != EV_NONE);
        park     = (kind == EV_CLOSE) && !in_ready && !close_pend;
        drop     = (((kind == EV_DATA) || (kind == EV_OPEN)) && !in_ready)
                || ((kind == EV_CLOSE) && close_pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_v     <= 1'b0;
            head_d     <= '0;
            sec_v      <= 1'b0;
            sec_d      <= '0;
            close_pend <= 1'b0;
        end else begin
            if (park) begin
                close_pend <= 1'b1;
            end
            if (free) begin
                if (sec_v) begin
                    head_v <= 1'b1;
                    head_d <= sec_d;
                    sec_v  <= 1'b0;
                end else if (close_pend) begin
                    head_v     <= 1'b1;
                    head_d     <= CH_DELIM;
                    sec_v      <= 1'b1;
                    sec_d      <= CH_DELIM;
                    close_pend <= 1'b0;
                end else if (take) begin
                    head_v <= 1'b1;
                    head_d <= emit.first;
                    sec_v  <= emit.two;
                    sec_d  <= emit.second;
                end else begin
                    head_v <= 1'b0;
                end
            end
        end
    end

    assign out_valid = head_v;
    assign out_data  = head_d;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_PAIR_STALL: assert property (@(posedge clk) disable iff (rst)
        (take && emit.two) |=> !in_ready); // R6

    AST_PARK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        park |=> !in_ready); // R7

endmodule

// File: rtl/frx_esc_ovf.sv
module frx_esc_ovf (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (drop) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/frx_escaper.sv
module frx_escaper
    import frx_esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    input  logic       stat_rd,
    output logic       ovf_flag
);

    ev_kind_e kind;
    emit_t    emit;
    logic     drop;

    always_comb begin
        if (in_sof) begin
            kind = EV_OPEN;
        end else if (in_eof) begin
            kind = EV_CLOSE;
        end else if (in_valid) begin
            kind = EV_DATA;
        end else begin
            kind = EV_NONE;
        end
    end

    frx_esc_encode i_encode (
        .kind (kind),
        .data (in_data),
        .emit (emit)
    );

    frx_esc_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .emit      (emit),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .in_ready  (in_ready),
        .drop      (drop)
    );

    frx_esc_ovf i_ovf (
        .clk  (clk),
        .rst  (rst),
        .drop (drop),
        .clr  (stat_rd),
        .flag (ovf_flag)
    );

    AST_ESC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_data == CH_ESC)
        |=> (out_valid && (out_data == 8'h5D || out_data == 8'h5E || out_data == 8'h5F))); // R4

    AST_NO_BARE_TOP: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data != CH_TOP)); // R4

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        ((in_valid || in_sof) && !in_ready) |=> ovf_flag); // R9

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !in_valid && !in_sof && !in_eof) |=> !ovf_flag); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_valid, in_sof, in_eof})); // R5

endmodule

// File: tb/test_frx_escaper.sv
`timescale 1ns/1ps
module test_frx_escaper;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       stat_rd = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;

    int got [0:255];
    int gcnt = 0;
    int exp_q [0:255];
    int ecnt = 0;

    always #4 clk = ~clk;

    frx_escaper i_frx_escaper (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .stat_rd   (stat_rd),
        .ovf_flag  (ovf_flag)
    );

    always @(posedge clk) begin
        if (!rst && out_valid && out_ready && gcnt < 256) begin
            got[gcnt] = int'(out_data);
            gcnt = gcnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input int b);
        exp_q[ecnt] = b;
        ecnt++;
    endtask

    task automatic push_data_exp(input int b);
        if (b == 'h7D || b == 'h7E || b == 'h7F) begin
            push_exp('h7D);
            push_exp(b ^ 'h20);
        end else begin
            push_exp(b);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        push_data_exp(int'(b));
    endtask

    task automatic send_open();
        while (!in_ready) @(negedge clk);
        in_sof = 1'b1;
        @(negedge clk);
        in_sof = 1'b0;
        push_exp('h7E);
        push_exp('h7E);
    endtask

    task automatic send_close();
        while (!in_ready) @(negedge clk);
        in_eof = 1'b1;
        @(negedge clk);
        in_eof = 1'b0;
        push_exp('h7E);
        push_exp('h7E);
    endtask

    task automatic drain_and_compare(input string req);
        repeat (8) @(negedge clk);
        chk({req, " byte count"}, gcnt, ecnt);
        for (int i = 0; i < ecnt && i < gcnt; i++) begin
            chk(req, got[i], exp_q[i]);
        end
        gcnt = 0;
        ecnt = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
    endtask

    // R2 R3 R5: plain frame, CRC bytes low first
    task automatic t_plain_frame();
        out_ready = 1'b1;
        send_open();
        send_byte(8'h01);
        send_byte(8'h11);
        send_byte(8'hC0);
        send_byte(8'hA1);
        send_byte(8'hB2);
        send_byte(8'hC3);
        send_byte(8'hD4);
        send_close();
        drain_and_compare("R2/R3/R5 plain frame");
        chk("R5 no overflow", int'(ovf_flag), 0);
    endtask

    // R4 R5: specials and their neighbours
    task automatic t_escapes();
        send_open();
        send_byte(8'h7C);
        send_byte(8'h7D);
        send_byte(8'h7E);
        send_byte(8'h7F);
        send_byte(8'h80);
        send_byte(8'h5D);
        send_byte(8'h20);
        send_byte(8'h7E);
        send_byte(8'h7E);
        send_close();
        drain_and_compare("R4 escape stream");
    endtask

    // R6: pair holds off input for one cycle
    task automatic t_pair_stall();
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h7F;
        @(negedge clk);
        in_valid = 1'b0;
        push_data_exp('h7F);
        chk("R6 ready low during pair", int'(in_ready), 0);
        chk("R11 first byte due", int'(out_data), 'h7D);
        @(negedge clk);
        chk("R6 ready back after pair", int'(in_ready), 1);
        drain_and_compare("R6 pair stream");
    endtask

    // R11: one-cycle latency
    task automatic t_latency();
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h33;
        @(negedge clk);
        in_valid = 1'b0;
        push_data_exp('h33);
        chk("R11 out_valid", int'(out_valid), 1);
        chk("R11 out_data", int'(out_data), 'h33);
        drain_and_compare("R11 stream");
    endtask

    // R7: close during escape pair
    task automatic t_close_in_pair();
        send_open();
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h7E;
        @(negedge clk);
        in_valid = 1'b0;
        push_data_exp('h7E);
        in_eof = 1'b1;
        @(negedge clk);
        in_eof = 1'b0;
        push_exp('h7E);
        push_exp('h7E);
        drain_and_compare("R7 close held behind pair");
        chk("R7 no overflow", int'(ovf_flag), 0);
    endtask

    // R8 R9 R10: stall, drop, clear
    task automatic t_overflow();
        out_ready = 1'b0;
        send_byte(8'h41);
        chk("R9 ready low when stalled", int'(in_ready), 0);
        in_valid = 1'b1;
        in_data  = 8'h42;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 flag set on drop", int'(ovf_flag), 1);
        repeat (3) @(negedge clk);
        chk("R8 held valid", int'(out_valid), 1);
        chk("R8 held data", int'(out_data), 'h41);
        chk("R9 flag sticky", int'(ovf_flag), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R10 flag cleared", int'(ovf_flag), 0);
        in_sof  = 1'b1;
        stat_rd = 1'b1;
        @(negedge clk);
        in_sof  = 1'b0;
        stat_rd = 1'b0;
        chk("R10 drop beats clear", int'(ovf_flag), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R10 flag cleared again", int'(ovf_flag), 0);
        out_ready = 1'b1;
        drain_and_compare("R9 dropped bytes absent");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_plain_frame();
        t_escapes();
        t_pair_stall();
        t_latency();
        t_close_in_pair();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule